// File: doc/BRIEF.md
# Chained-Buffer Peripheral DMA Channel

This block is a single DMA channel that moves words between one peripheral and system memory. Software gives it an active buffer, made of a start address and a transfer count, and can queue a second buffer in a pair of "next" registers. Each time the peripheral raises its request line while the channel is enabled and the active count is non-zero, the channel makes one memory access. It then acknowledges the peripheral, advances the address by the word size and decrements the count.

When the active count reaches zero the channel raises an end-of-buffer flag. If a next buffer is queued, the hardware copies it into the active registers, clears the next registers, and carries on without software help. If nothing is queued, a second flag reports that the whole chain is done, and no further transfers start. A build-time parameter sets the direction. A receive channel writes peripheral data into memory, where the chain-done flag means "buffer full". A transmit channel reads memory and hands the data to the peripheral, where the flag means "buffer empty". Bus arbitration and the peripheral itself lie outside the block.

Top module: `pdma_chan`

## Requirements
- R1: After reset every pointer and counter register reads zero and the channel is disabled. `mem_req` and `per_ack` are low, and both `irq_end` and `irq_all` are high.
- R2: The register port decodes these addresses: 0 active pointer, 1 active count (16 bits), 2 next pointer, 3 next count, 4 control, 5 status. A write to control sets the enable when bit 0 is 1 and clears it when bit 1 is 1; disable wins when both bits are set. Status reads bit 0 = enabled, bit 1 = `irq_end`, bit 2 = `irq_all`. Reads are combinational.
- R3: `mem_req` rises in the cycle after a clock edge at which the channel is idle and enabled, the active count is non-zero and `per_req` is high. `mem_addr` then equals the active pointer.
- R4: A transfer completes in the cycle in which `mem_req` and `mem_ready` are both high. `per_ack` is high in that cycle only. In the next cycle the count is one lower and `mem_req` is low. While `mem_ready` is low, `mem_req` stays high.
- R5: `wsize` selects the word size: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. After each completed transfer the pointer grows by 1, 2 or 4 respectively, with no alignment applied.
- R6: A receive channel drives `mem_we` = 1 and `mem_wdata` = `per_din` with the bits above the word size cleared. A transmit channel drives `mem_we` = 0. In the cycle after completion, `per_dout` holds `mem_rdata` with the bits above the word size cleared.
- R7: `irq_end` is high exactly while the active count is zero, including the cycle between the last transfer of a buffer and a reload.
- R8: In a cycle where the active count is zero, the next count is non-zero, no register write occurs and no transfer completes, the next edge copies the next pointer and count into the active registers and clears both next registers.
- R9: `irq_all` is high while both counts are zero. In that state no transfer starts, whatever `per_req` does.
- R10: While disabled the channel starts no transfer. A transfer already in progress when the channel is disabled still completes.
- R11: A software write to a pointer or count register replaces its value even while the channel runs. It takes priority over the hardware update of that register in the same cycle, and the flags follow the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wsize | input | 2 | Word size select |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| per_req | input | 1 | Peripheral transfer request |
| per_ack | output | 1 | Peripheral acknowledge, one cycle per transfer |
| per_din | input | 32 | Data from peripheral (receive) |
| per_dout | output | 32 | Data to peripheral (transmit) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_ready | input | 1 | Memory completes the access this cycle |
| irq_end | output | 1 | Active buffer finished |
| irq_all | output | 1 | Active and next buffers finished |

## Verification
The results fall due at fixed distances from a stimulus:
- `mem_req` rises one edge after the request is seen.
- `per_ack` follows `mem_ready` in the same cycle.
- Pointer, count and `per_dout` change at the edge that ends the access.
- A reload needs one further edge after the count reaches zero.
- Flags and register reads are combinational on register state, so they are valid as soon as that state settles.

The bench drives all inputs on the falling edge and samples on the falling edge that follows the rising edge where each result is due. It reads registers only in the low half of the clock. The sweep covers every word size against buffers of one to four transfers.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  // register addresses
  localparam logic [2:0] RA_PTR  = 3'd0;
  localparam logic [2:0] RA_CNT  = 3'd1;
  localparam logic [2:0] RA_NPTR = 3'd2;
  localparam logic [2:0] RA_NCNT = 3'd3;
  localparam logic [2:0] RA_CTRL = 3'd4;
  localparam logic [2:0] RA_STAT = 3'd5;

  // address increment for a word size code
  function automatic logic [2:0] step_of(input logic [1:0] ws);
    case (ws)
      2'd0:    step_of = 3'd1;
      2'd1:    step_of = 3'd2;
      default: step_of = 3'd4;
    endcase
  endfunction

  // keep only the lanes that belong to the word size
  function automatic logic [31:0] lane_mask(input logic [1:0] ws, input logic [31:0] d);
    case (ws)
      2'd0:    lane_mask = {24'h0, d[7:0]};
      2'd1:    lane_mask = {16'h0, d[15:0]};
      default: lane_mask = d;
    endcase
  endfunction
endpackage

// File: rtl/pdma_regs.sv
module pdma_regs
  import pdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [1:0]        wsize,
  input  logic              xfer_done,
  output logic [ADDR_W-1:0] ptr_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [ADDR_W-1:0] nptr_q,
  output logic [CNT_W-1:0]  ncnt_q,
  output logic              en_q,
  output logic              end_flag,
  output logic              all_flag,
  output logic              reload_fire
);
  logic wr_ptr, wr_cnt, wr_nptr, wr_ncnt, wr_ctrl, any_buf_wr;
  logic [ADDR_W-1:0] step_ext;

  assign wr_ptr     = reg_we && (reg_addr == RA_PTR);
  assign wr_cnt     = reg_we && (reg_addr == RA_CNT);
  assign wr_nptr    = reg_we && (reg_addr == RA_NPTR);
  assign wr_ncnt    = reg_we && (reg_addr == RA_NCNT);
  assign wr_ctrl    = reg_we && (reg_addr == RA_CTRL);
  assign any_buf_wr = wr_ptr || wr_cnt || wr_nptr || wr_ncnt;

  assign step_ext   = ADDR_W'(step_of(wsize));

  assign end_flag    = (cnt_q == '0);
  assign all_flag    = end_flag && (ncnt_q == '0);
  assign reload_fire = end_flag && (ncnt_q != '0) && !any_buf_wr && !xfer_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      cnt_q  <= '0;
      nptr_q <= '0;
      ncnt_q <= '0;
      en_q   <= 1'b0;
    end else begin
      // active pointer: software, then reload, then advance
      if (wr_ptr)           ptr_q <= reg_wdata[ADDR_W-1:0];
      else if (reload_fire) ptr_q <= nptr_q;
      else if (xfer_done)   ptr_q <= ptr_q + step_ext;

      if (wr_cnt)                        cnt_q <= reg_wdata[CNT_W-1:0];
      else if (reload_fire)              cnt_q <= ncnt_q;
      else if (xfer_done && !end_flag)   cnt_q <= cnt_q - 1'b1;

      if (wr_nptr)          nptr_q <= reg_wdata[ADDR_W-1:0];
      else if (reload_fire) nptr_q <= '0;

      if (wr_ncnt)          ncnt_q <= reg_wdata[CNT_W-1:0];
      else if (reload_fire) ncnt_q <= '0;

      if (wr_ctrl) begin
        if (reg_wdata[1])      en_q <= 1'b0;
        else if (reg_wdata[0]) en_q <= 1'b1;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      RA_PTR:  reg_rdata = 32'(ptr_q);
      RA_CNT:  reg_rdata = 32'(cnt_q);
      RA_NPTR: reg_rdata = 32'(nptr_q);
      RA_NCNT: reg_rdata = 32'(ncnt_q);
      RA_STAT: reg_rdata = {29'h0, all_flag, end_flag, en_q};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pdma_engine.sv
module pdma_engine
  import pdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter bit DIR_RX = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cnt_nz,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [1:0]        wsize,
  input  logic              per_req,
  input  logic [31:0]       per_din,
  output logic              per_ack,
  output logic [31:0]       per_dout,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ready,
  output logic              xfer_start,
  output logic              xfer_done
);
  logic busy_q;

  assign xfer_start = !busy_q && en && cnt_nz && per_req;
  assign xfer_done  = busy_q && mem_ready;

  assign mem_req  = busy_q;
  assign mem_addr = ptr;
  assign per_ack  = xfer_done;

  generate
    if (DIR_RX) begin : g_rx
      assign mem_we    = 1'b1;
      assign mem_wdata = lane_mask(wsize, per_din);
    end else begin : g_tx
      assign mem_we    = 1'b0;
      assign mem_wdata = lane_mask(wsize, per_din) & 32'h0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      per_dout <= '0;
    end else begin
      if (xfer_start)     busy_q <= 1'b1;
      else if (xfer_done) busy_q <= 1'b0;
      if (xfer_done && !DIR_RX) per_dout <= lane_mask(wsize, mem_rdata);
    end
  end
endmodule

// File: rtl/pdma_chan.sv
module pdma_chan
  import pdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter bit DIR_RX = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        wsize,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              per_req,
  output logic              per_ack,
  input  logic [31:0]       per_din,
  output logic [31:0]       per_dout,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ready,
  output logic              irq_end,
  output logic              irq_all
);
  // named internal events, visible to the bound checker
  logic [ADDR_W-1:0] ptr_q, nptr_q;
  logic [CNT_W-1:0]  cnt_q, ncnt_q;
  logic              en_q, reload_fire, xfer_start, xfer_done;

  pdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wsize(wsize), .xfer_done(xfer_done),
    .ptr_q(ptr_q), .cnt_q(cnt_q), .nptr_q(nptr_q), .ncnt_q(ncnt_q), .en_q(en_q),
    .end_flag(irq_end), .all_flag(irq_all), .reload_fire(reload_fire)
  );

  pdma_engine #(.ADDR_W(ADDR_W), .DIR_RX(DIR_RX)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .en(en_q), .cnt_nz(cnt_q != '0), .ptr(ptr_q), .wsize(wsize),
    .per_req(per_req), .per_din(per_din), .per_ack(per_ack), .per_dout(per_dout),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .xfer_start(xfer_start), .xfer_done(xfer_done)
  );
endmodule

// File: rtl/pdma_chan_chk.sv
module pdma_chan_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [2:0]        reg_addr,
  input logic [1:0]        ctl_bits,
  input logic              per_req,
  input logic              per_ack,
  input logic              mem_req,
  input logic              mem_ready,
  input logic              irq_all,
  input logic              en,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  ncnt,
  input logic [ADDR_W-1:0] nptr
);
  assert_start_cond_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(en && (cnt != '0) && per_req));

  assert_ack_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |=> !per_ack);

  assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> mem_req);

  assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (per_ack && !reg_we && (cnt != '0)) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

  assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt == '0) && (ncnt != '0) && !reg_we && !per_ack)
      |=> ((cnt == $past(ncnt)) && (ncnt == '0) && (nptr == '0)));

  assert_chain_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_all && !mem_req) |=> !mem_req);

  assert_no_start_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !mem_req) |=> !mem_req);

  assert_disable_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (reg_addr == 3'd4) && ctl_bits[1]) |=> !en);
endmodule

bind pdma_chan pdma_chan_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .ctl_bits(reg_wdata[1:0]), .per_req(per_req), .per_ack(per_ack),
  .mem_req(mem_req), .mem_ready(mem_ready), .irq_all(irq_all),
  .en(en_q), .cnt(cnt_q), .ncnt(ncnt_q), .nptr(nptr_q)
);

// File: tb/test_pdma_chan.sv
`timescale 1ns/1ps
module test_pdma_chan;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // receive channel
  logic [1:0]  wsize = 2'd0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        per_req = 1'b0, per_ack;
  logic [31:0] per_din = '0, per_dout;
  logic        mem_req, mem_we, mem_ready = 1'b1;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        irq_end, irq_all;

  // transmit channel
  logic [1:0]  t_wsize = 2'd1;
  logic        t_reg_we = 1'b0;
  logic [2:0]  t_reg_addr = 3'd0;
  logic [31:0] t_reg_wdata = '0;
  logic [31:0] t_reg_rdata;
  logic        t_per_req = 1'b0, t_per_ack;
  logic [31:0] t_per_din = 32'hFFFF_FFFF, t_per_dout;
  logic        t_mem_req, t_mem_we, t_mem_ready = 1'b1;
  logic [31:0] t_mem_addr, t_mem_wdata, t_mem_rdata = '0;
  logic        t_irq_end, t_irq_all;

  pdma_chan #(.DIR_RX(1'b1)) i_pdma_chan (
    .clk(clk), .rst_n(rst_n), .wsize(wsize), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_req(per_req), .per_ack(per_ack),
    .per_din(per_din), .per_dout(per_dout), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .irq_end(irq_end), .irq_all(irq_all));

  pdma_chan #(.DIR_RX(1'b0)) i_pdma_chan_tx (
    .clk(clk), .rst_n(rst_n), .wsize(t_wsize), .reg_we(t_reg_we), .reg_addr(t_reg_addr),
    .reg_wdata(t_reg_wdata), .reg_rdata(t_reg_rdata), .per_req(t_per_req), .per_ack(t_per_ack),
    .per_din(t_per_din), .per_dout(t_per_dout), .mem_req(t_mem_req), .mem_we(t_mem_we),
    .mem_addr(t_mem_addr), .mem_wdata(t_mem_wdata), .mem_rdata(t_mem_rdata),
    .mem_ready(t_mem_ready), .irq_end(t_irq_end), .irq_all(t_irq_all));

  function automatic logic [31:0] exp_step(input int ws);
    return (ws >= 2) ? 32'd4 : 32'(ws + 1);
  endfunction

  function automatic logic [31:0] exp_mask(input int ws);
    return (ws == 0) ? 32'h0000_00FF : (ws == 1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic twr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); t_reg_we = 1'b1; t_reg_addr = a; t_reg_wdata = d;
    @(negedge clk); t_reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a; #0.5; v = reg_rdata;
  endtask

  task automatic rdchk(input string req, input string what, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, what, v, exp);
  endtask

  // one receive transfer with memory ready at once
  task automatic xfer_rx(input logic [31:0] din, input logic [31:0] exp_addr, input int ws);
    @(negedge clk); per_req = 1'b1; per_din = din;
    @(negedge clk); per_req = 1'b0;
    chk("R3", "mem_req up", 32'(mem_req), 32'd1);
    chk("R3", "mem_addr", mem_addr, exp_addr);
    chk("R6", "mem_we rx", 32'(mem_we), 32'd1);
    chk("R6", "mem_wdata", mem_wdata, din & exp_mask(ws));
    chk("R4", "per_ack", 32'(per_ack), 32'd1);
    @(negedge clk);
    chk("R4", "ack one cycle", 32'(per_ack), 32'd0);
    chk("R4", "mem_req drops", 32'(mem_req), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected end of run");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdchk("R1", "ptr", 3'd0, 32'd0);
    rdchk("R1", "cnt", 3'd1, 32'd0);
    rdchk("R1", "nptr", 3'd2, 32'd0);
    rdchk("R1", "ncnt", 3'd3, 32'd0);
    rdchk("R1", "status", 3'd5, 32'b110);
    chk("R1", "mem_req", 32'(mem_req), 32'd0);
    chk("R1", "per_ack", 32'(per_ack), 32'd0);
    chk("R1", "irq_end", 32'(irq_end), 32'd1);
    chk("R1", "irq_all", 32'(irq_all), 32'd1);

    // sweep: every word size against buffers of 1..4 transfers
    for (int ws = 0; ws < 4; ws++) begin
      for (int n = 1; n <= 4; n++) begin
        wsize = 2'(ws);
        base = 32'h1000 * 32'(ws + 1) + 32'h40 * 32'(n) + 32'd1;
        wr(3'd0, base);
        wr(3'd1, 32'(n));
        wr(3'd4, 32'd1);
        chk("R7", "end low when loaded", 32'(irq_end), 32'd0);
        for (int k = 0; k < n; k++) begin
          xfer_rx(32'hA5C3_5A3C ^ (32'(ws) << 20) ^ (32'(n) << 8) ^ (32'(k) * 32'h0101_0111),
                  base + 32'(k) * exp_step(ws), ws);
          rdchk("R4", "count after", 3'd1, 32'(n - k - 1));
          rdchk("R5", "pointer after", 3'd0, base + 32'(k + 1) * exp_step(ws));
        end
        chk("R7", "end flag", 32'(irq_end), 32'd1);
        chk("R9", "all flag", 32'(irq_all), 32'd1);
        rdchk("R2", "status", 3'd5, 32'b111);
        @(negedge clk); per_req = 1'b1;
        repeat (3) begin
          @(negedge clk);
          chk("R9", "no start at chain end", 32'(mem_req), 32'd0);
        end
        per_req = 1'b0;
      end
    end

    // R8 chaining into a queued buffer
    wsize = 2'd2;
    wr(3'd0, 32'h2000);
    wr(3'd1, 32'd2);
    wr(3'd2, 32'h3000);
    wr(3'd3, 32'd3);
    chk("R9", "all low while queued", 32'(irq_all), 32'd0);
    xfer_rx(32'h1111_2222, 32'h2000, 2);
    xfer_rx(32'h3333_4444, 32'h2004, 2);
    chk("R7", "end high before reload", 32'(irq_end), 32'd1);
    chk("R9", "all low before reload", 32'(irq_all), 32'd0);
    rdchk("R7", "count zero", 3'd1, 32'd0);
    @(negedge clk);
    rdchk("R8", "reloaded count", 3'd1, 32'd3);
    rdchk("R8", "reloaded ptr", 3'd0, 32'h3000);
    rdchk("R8", "next ptr cleared", 3'd2, 32'd0);
    rdchk("R8", "next count cleared", 3'd3, 32'd0);
    chk("R7", "end low after reload", 32'(irq_end), 32'd0);
    for (int k = 0; k < 3; k++) xfer_rx(32'h5555_0000 + 32'(k), 32'h3000 + 32'(4 * k), 2);
    chk("R9", "all after second buffer", 32'(irq_all), 32'd1);

    // R10 disable
    wr(3'd0, 32'h500);
    wr(3'd1, 32'd4);
    wr(3'd4, 32'd3);
    rdchk("R2", "disable wins", 3'd5, 32'd0);
    @(negedge clk); per_req = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk("R10", "no start disabled", 32'(mem_req), 32'd0);
    end
    per_req = 1'b0;
    wr(3'd4, 32'd1);
    mem_ready = 1'b0;
    @(negedge clk); per_req = 1'b1;
    @(negedge clk); per_req = 1'b0;
    chk("R4", "stall req", 32'(mem_req), 32'd1);
    chk("R4", "stall no ack", 32'(per_ack), 32'd0);
    reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 32'd2;
    @(negedge clk); reg_we = 1'b0;
    chk("R10", "in flight kept", 32'(mem_req), 32'd1);
    rdchk("R10", "disabled", 3'd5, 32'd0);
    mem_ready = 1'b1; #0.5;
    chk("R10", "in flight acks", 32'(per_ack), 32'd1);
    @(negedge clk);
    rdchk("R10", "count after", 3'd1, 32'd3);
    rdchk("R10", "ptr after", 3'd0, 32'h504);

    // R11 software overwrite
    wr(3'd4, 32'd1);
    xfer_rx(32'h0BAD_F00D, 32'h504, 2);
    wr(3'd1, 32'd9);
    rdchk("R11", "count replaced", 3'd1, 32'd9);
    mem_ready = 1'b0;
    @(negedge clk); per_req = 1'b1;
    @(negedge clk); per_req = 1'b0;
    reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 32'd7; mem_ready = 1'b1;
    @(negedge clk); reg_we = 1'b0;
    rdchk("R11", "write beats decrement", 3'd1, 32'd7);
    rdchk("R5", "ptr still steps", 3'd0, 32'h50C);
    wr(3'd1, 32'd0);
    chk("R11", "flags follow write", 32'(irq_all), 32'd1);

    // transmit channel
    twr(3'd0, 32'h80);
    twr(3'd1, 32'd2);
    twr(3'd4, 32'd1);
    t_mem_rdata = 32'hA5A5_1234;
    @(negedge clk); t_per_req = 1'b1;
    @(negedge clk); t_per_req = 1'b0;
    chk("R6", "tx mem_we", 32'(t_mem_we), 32'd0);
    chk("R3", "tx addr", t_mem_addr, 32'h80);
    chk("R4", "tx ack", 32'(t_per_ack), 32'd1);
    @(negedge clk);
    chk("R6", "tx dout half", t_per_dout, 32'h0000_1234);
    t_wsize = 2'd0; t_mem_rdata = 32'h0102_03F7;
    @(negedge clk); t_per_req = 1'b1;
    @(negedge clk); t_per_req = 1'b0;
    chk("R5", "tx addr byte step", t_mem_addr, 32'h82);
    @(negedge clk);
    chk("R6", "tx dout byte", t_per_dout, 32'h0000_00F7);
    chk("R9", "tx empty flag", 32'(t_irq_all), 32'd1);

    summary();
    $finish;
  end
endmodule